// File: doc/BRIEF.md
# NAND Flash Device-Side Bus Front End

This block sits on the device side of an 8-bit NAND-style flash bus. It watches the host strobes (command latch, address latch, write, read, chip select, spare select and write protect) and the byte lanes. It sorts every write cycle into one of three kinds: a command byte, an address byte or a data-in byte. Each kind is handed to the page buffer and array sequencer as a single-cycle strobe on a simple internal port.

A column address counter tracks the byte position inside the page. The first address byte of a sequence loads the counter, and every data-in byte and every read strobe advances it by one. Read data for the current column comes from the page buffer and is driven onto the bus whenever the chip is selected and the read strobe is low.

The ready/busy line is modelled as an open-drain pull-down request that follows the sequencer's busy flag. Releasing chip select while the sequencer is busy leaves the interface state alone. Releasing it while idle returns the block to standby. The write, read and chip-select strobes pass through two-flop synchronisers before their edges are detected. The other bus levels are sampled at the detected edge.

Top module: `nand_bus_front`

## Requirements
- R1: With chip select low, a write-strobe rising edge with command latch high and address latch low produces one `cmd_vld_o` pulse carrying the bus byte on `cmd_o`. It also restarts the address byte sequence.
- R2: With address latch high and command latch low, the first address byte after a command loads the column counter (a value beyond the last column clamps to it) and is reported with index 0. The next ROW_BYTES bytes are reported on `addr_vld_o` with indices 1 to ROW_BYTES. Further address bytes produce no pulse and leave the column unchanged.
- R3: With both latch enables low, a write cycle produces one `din_vld_o` pulse carrying the byte, and `col_o` still holds the column of that byte during the pulse. The column then advances by one.
- R4: A write cycle with both latch enables high is ignored. It produces no pulse of any kind and does not change the column.
- R5: A falling edge of the read strobe with chip select low latches the page buffer byte for the current column onto `io_out_o` and advances the column by one. The column wraps from MAIN_BYTES+SPARE_BYTES-1 to 0. After reset the column is 0.
- R6: `io_oe_o` is 1 only while both the synchronised chip select and the synchronised read strobe are low. It is 0 after reset, whenever the chip is deselected, and whenever the read strobe is high.
- R7: A rising edge of chip select while `busy_i` is 0 clears the column and the address sequence. While `busy_i` is 1, the same edge has no effect and the column is kept.
- R8: `rb_pull_o` (1 = pull the ready/busy line low) equals `busy_i` delayed by one clock. It is independent of chip select and read strobe, and it is 0 after reset.
- R9: While `wp_n_i` is 0, the command bytes 8'h80, 8'h10, 8'h60 and 8'hD0 (program and erase codes) produce no command pulse. All other command bytes pass. While `wp_n_i` is 1, all command bytes pass.
- R10: While `se_i` is 1, columns at or above MAIN_BYTES are excluded from access. A data-in byte there gives no `din_vld_o` pulse, and a read returns 8'hFF. The column still advances in both cases.
- R11: Write and read strobes seen while chip select is high produce no pulse and do not move the column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cle_i | input | 1 | Command latch enable level |
| ale_i | input | 1 | Address latch enable level |
| we_n_i | input | 1 | Write strobe, active low, asynchronous |
| re_n_i | input | 1 | Read strobe, active low, asynchronous |
| ce_n_i | input | 1 | Chip select, active low, asynchronous |
| se_i | input | 1 | Spare-area exclusion level |
| wp_n_i | input | 1 | Write protect, active low |
| io_in_i | input | 8 | Byte lanes as seen from the bus |
| io_out_o | output | 8 | Read byte to drive onto the bus |
| io_oe_o | output | 1 | Bus output enable; 0 means high impedance |
| rb_pull_o | output | 1 | Open-drain ready/busy pull-down request |
| rd_data_i | input | 8 | Page buffer byte at column `col_o` |
| busy_i | input | 1 | Program, erase or page-load in progress |
| col_o | output | COL_W | Current column address |
| cmd_vld_o | output | 1 | Command byte strobe |
| cmd_o | output | 8 | Command byte |
| addr_vld_o | output | 1 | Address byte strobe |
| addr_idx_o | output | ACNT_W | Position of the address byte in its sequence |
| addr_byte_o | output | 8 | Address byte |
| din_vld_o | output | 1 | Data-in byte strobe |
| din_o | output | 8 | Data-in byte |

## Verification
The assertions assume the bus levels (latch enables, byte lanes, spare select and write protect) stay steady from the moment a write or read strobe changes until its edge has crossed the synchroniser and been acted on. They also assume that at most one strobe edge reaches the decode stage in any cycle. The stimulus holds every strobe level for six clocks and changes only one strobe at a time. It moves the level inputs only while all strobes are idle. The random phase draws cycle kinds, bytes, spare select and write protect from a seeded generator and keeps to these same timing rules.

// File: rtl/nand_fe_pkg.sv
// Shared constants and helpers for the NAND bus front end.
// Assumes 8-bit byte lanes.
package nand_fe_pkg;
    localparam logic [7:0] CMD_PROG_SETUP  = 8'h80;
    localparam logic [7:0] CMD_PROG_GO     = 8'h10;
    localparam logic [7:0] CMD_ERASE_SETUP = 8'h60;
    localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;

    typedef enum logic [1:0] {
        CYC_NONE,
        CYC_CMD,
        CYC_ADDR,
        CYC_DATA
    } cyc_kind_e;

    // True for command codes that start or confirm a program or erase.
    function automatic logic is_protected(input logic [7:0] code);
        return (code == CMD_PROG_SETUP) || (code == CMD_PROG_GO) ||
               (code == CMD_ERASE_SETUP) || (code == CMD_ERASE_GO);
    endfunction
endpackage

// File: rtl/nand_strobe_sync.sv
// Two-flop synchronisers for N asynchronous active-low strobes, plus a third
// stage that keeps the previous synchronised value for edge detection.
// Assumes the inactive (high) level during reset.
module nand_strobe_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o,
    output logic [N-1:0] prev_o
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_bit
            logic s1, s2, s3;
            // Three-stage shift: two to synchronise, one to remember.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    s1 <= 1'b1;
                    s2 <= 1'b1;
                    s3 <= 1'b1;
                end else begin
                    s1 <= async_i[g];
                    s2 <= s1;
                    s3 <= s2;
                end
            end
            assign sync_o[g] = s2;
            assign prev_o[g] = s3;
        end
    endgenerate
endmodule

// File: rtl/nand_cycle_decode.sv
// Classifies each write-strobe rising edge into a command, address or data
// cycle from the latch-enable levels and emits a one-cycle registered pulse.
// Assumes the bus levels are stable while the edge is detected.
module nand_cycle_decode
    import nand_fe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we_rise_i,
    input  logic       ce_act_i,
    input  logic       cle_i,
    input  logic       ale_i,
    input  logic [7:0] io_i,
    input  logic       wp_n_i,
    output logic       cmd_vld_o,
    output logic       addr_vld_o,
    output logic       din_vld_o,
    output logic [7:0] byte_o
);
    cyc_kind_e kind;

    // Pick the cycle kind; illegal and protected cycles become CYC_NONE.
    always_comb begin
        kind = CYC_NONE;
        if (we_rise_i && ce_act_i) begin
            unique case ({cle_i, ale_i})
                2'b10: kind = (!wp_n_i && is_protected(io_i)) ? CYC_NONE : CYC_CMD;
                2'b01: kind = CYC_ADDR;
                2'b00: kind = CYC_DATA;
                default: kind = CYC_NONE;
            endcase
        end
    end

    // Register the pulses and the byte that travels with them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_vld_o  <= 1'b0;
            addr_vld_o <= 1'b0;
            din_vld_o  <= 1'b0;
            byte_o     <= 8'h00;
        end else begin
            cmd_vld_o  <= (kind == CYC_CMD);
            addr_vld_o <= (kind == CYC_ADDR);
            din_vld_o  <= (kind == CYC_DATA);
            if (kind != CYC_NONE) byte_o <= io_i;
        end
    end

    // R1
    one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_vld_o, addr_vld_o, din_vld_o}));
    // R4
    illegal_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_rise_i && cle_i && ale_i) |=> !cmd_vld_o && !addr_vld_o && !din_vld_o);
    // R9
    wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld_o |-> !(!$past(wp_n_i) && is_protected(byte_o)));
endmodule

// File: rtl/nand_col_counter.sv
// Column address counter and address-byte sequencer. The first address byte
// loads the column, and data-in and read events advance it with wrap at the page end.
// Assumes at most one event per cycle.
module nand_col_counter #(
    parameter int MAIN_BYTES  = 224,
    parameter int SPARE_BYTES = 32,
    parameter int ROW_BYTES   = 2,
    localparam int TOTAL  = MAIN_BYTES + SPARE_BYTES,
    localparam int COL_W  = $clog2(TOTAL),
    localparam int ACNT_W = $clog2(ROW_BYTES + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_vld_i,
    input  logic              addr_vld_i,
    input  logic              din_vld_i,
    input  logic [7:0]        byte_i,
    input  logic              rd_fall_i,
    input  logic              ce_rise_i,
    input  logic              busy_i,
    output logic [COL_W-1:0]  col_o,
    output logic [ACNT_W-1:0] acnt_o
);
    localparam logic [COL_W-1:0]  LAST_C = COL_W'(TOTAL - 1);
    localparam logic [ACNT_W-1:0] ROW_C  = ACNT_W'(ROW_BYTES);

    logic [COL_W-1:0] load_val;
    logic [COL_W-1:0] next_col;

    // Clamp an out-of-range column load and compute the wrapped successor.
    always_comb begin
        load_val = (int'(byte_i) >= TOTAL) ? LAST_C : COL_W'(byte_i);
        next_col = (col_o == LAST_C) ? '0 : col_o + COL_W'(1);
    end

    // Update column and address count; deselect-while-idle wins over all.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_o  <= '0;
            acnt_o <= '0;
        end else if (ce_rise_i && !busy_i) begin
            col_o  <= '0;
            acnt_o <= '0;
        end else if (cmd_vld_i) begin
            acnt_o <= '0;
        end else if (addr_vld_i) begin
            if (acnt_o == '0) col_o <= load_val;
            if (acnt_o <= ROW_C) acnt_o <= acnt_o + ACNT_W'(1);
        end else if (din_vld_i || rd_fall_i) begin
            col_o <= next_col;
        end
    end

    // R5
    rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fall_i && !ce_rise_i && !addr_vld_i && !din_vld_i && !cmd_vld_i && col_o != LAST_C)
        |=> col_o == $past(col_o) + COL_W'(1));
    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_rise_i && busy_i && !rd_fall_i && !addr_vld_i && !din_vld_i) |=> $stable(col_o));
endmodule

// File: rtl/nand_bus_front.sv
// Device-side front end of an 8-bit NAND flash bus. It synchronises the strobes,
// decodes write cycles, keeps the column counter, drives read data and
// requests the open-drain ready/busy pull-down. Assumes the bus levels are stable
// around each strobe edge.
module nand_bus_front #(
    parameter int MAIN_BYTES  = 224,
    parameter int SPARE_BYTES = 32,
    parameter int ROW_BYTES   = 2,
    localparam int COL_W  = $clog2(MAIN_BYTES + SPARE_BYTES),
    localparam int ACNT_W = $clog2(ROW_BYTES + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cle_i,
    input  logic              ale_i,
    input  logic              we_n_i,
    input  logic              re_n_i,
    input  logic              ce_n_i,
    input  logic              se_i,
    input  logic              wp_n_i,
    input  logic [7:0]        io_in_i,
    output logic [7:0]        io_out_o,
    output logic              io_oe_o,
    output logic              rb_pull_o,
    input  logic [7:0]        rd_data_i,
    input  logic              busy_i,
    output logic [COL_W-1:0]  col_o,
    output logic              cmd_vld_o,
    output logic [7:0]        cmd_o,
    output logic              addr_vld_o,
    output logic [ACNT_W-1:0] addr_idx_o,
    output logic [7:0]        addr_byte_o,
    output logic              din_vld_o,
    output logic [7:0]        din_o
);
    localparam logic [COL_W-1:0]  MAIN_C = COL_W'(MAIN_BYTES);
    localparam logic [ACNT_W-1:0] ROW_C  = ACNT_W'(ROW_BYTES);

    logic [2:0] strb_sync, strb_prev;
    logic we_rise, rd_fall, ce_rise, ce_act;
    logic dec_cmd, dec_addr, dec_din;
    logic [7:0] dec_byte;
    logic [ACNT_W-1:0] acnt;
    logic col_open;
    logic [7:0] rd_q;
    logic rb_q;

    nand_strobe_sync #(.N(3)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ce_n_i, re_n_i, we_n_i}),
        .sync_o  (strb_sync),
        .prev_o  (strb_prev)
    );

    // Edge detection on the synchronised strobes (bit 0 WE, 1 RE, 2 CE).
    always_comb begin
        ce_act  = !strb_sync[2];
        we_rise = strb_sync[0] && !strb_prev[0];
        rd_fall = !strb_sync[1] && strb_prev[1] && ce_act;
        ce_rise = strb_sync[2] && !strb_prev[2];
        col_open = !se_i || (col_o < MAIN_C);
    end

    nand_cycle_decode dec_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_rise_i  (we_rise),
        .ce_act_i   (ce_act),
        .cle_i      (cle_i),
        .ale_i      (ale_i),
        .io_i       (io_in_i),
        .wp_n_i     (wp_n_i),
        .cmd_vld_o  (dec_cmd),
        .addr_vld_o (dec_addr),
        .din_vld_o  (dec_din),
        .byte_o     (dec_byte)
    );

    nand_col_counter #(
        .MAIN_BYTES  (MAIN_BYTES),
        .SPARE_BYTES (SPARE_BYTES),
        .ROW_BYTES   (ROW_BYTES)
    ) ctr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_vld_i  (dec_cmd),
        .addr_vld_i (dec_addr),
        .din_vld_i  (dec_din),
        .byte_i     (dec_byte),
        .rd_fall_i  (rd_fall),
        .ce_rise_i  (ce_rise),
        .busy_i     (busy_i),
        .col_o      (col_o),
        .acnt_o     (acnt)
    );

    // Latch the read byte on each read-strobe falling edge; spare reads give FF.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= 8'h00;
        else if (rd_fall) rd_q <= col_open ? rd_data_i : 8'hFF;
    end

    // Register the ready/busy pull-down request from the sequencer flag.
    always_ff @(posedge clk) begin
        if (!rst_n) rb_q <= 1'b0;
        else rb_q <= busy_i;
    end

    // Internal port: gate address overflow and excluded spare writes.
    always_comb begin
        cmd_vld_o   = dec_cmd;
        cmd_o       = dec_byte;
        addr_vld_o  = dec_addr && (acnt <= ROW_C);
        addr_idx_o  = acnt;
        addr_byte_o = dec_byte;
        din_vld_o   = dec_din && col_open;
        din_o       = dec_byte;
        io_out_o    = rd_q;
        io_oe_o     = ce_act && !strb_sync[1];
        rb_pull_o   = rb_q;
    end

    // R8
    rb_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> rb_pull_o);
    // R10
    spare_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        din_vld_o |-> (!se_i || col_o < MAIN_C));
endmodule

// File: tb/nand_bus_front_tb.sv
// Self-checking bench: directed corners followed by seeded random bus cycles,
// checked against a bench-side model of column, address sequence and pulses.
module nand_bus_front_tb_top;
    localparam int MAIN  = 224;
    localparam int SPARE = 32;
    localparam int ROWB  = 2;
    localparam int TOTAL = MAIN + SPARE;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cle = 0, ale = 0, we_n = 1, re_n = 1, ce_n = 0, se = 0, wp_n = 1, busy = 0;
    logic [7:0] io_in = 8'h00;
    logic [7:0] io_out, rd_data, cmd, abyte, din;
    logic io_oe, rb_pull, cmd_vld, addr_vld, din_vld;
    logic [7:0] col;
    logic [1:0] aidx;

    int checks = 0, errors = 0;
    int n_cmd = 0, n_addr = 0, n_din = 0;
    logic [7:0] l_cmd, l_abyte, l_din, l_dcol;
    logic [1:0] l_aidx;
    int m_col = 0, m_acnt = 0;
    bit done = 0;

    always #2 clk = ~clk;

    function automatic logic [7:0] pat(input int c);
        return 8'(c * 37 + 5);
    endfunction
    function automatic bit sel(input int c, input bit s);
        return !s || c < MAIN;
    endfunction
    function automatic int nxt(input int c);
        return (c == TOTAL - 1) ? 0 : c + 1;
    endfunction
    function automatic bit prot(input logic [7:0] c);
        return c == 8'h80 || c == 8'h10 || c == 8'h60 || c == 8'hD0;
    endfunction

    assign rd_data = pat(int'(col));

    nand_bus_front #(.MAIN_BYTES(MAIN), .SPARE_BYTES(SPARE), .ROW_BYTES(ROWB)) dut_i (
        .clk(clk), .rst_n(rst_n), .cle_i(cle), .ale_i(ale), .we_n_i(we_n),
        .re_n_i(re_n), .ce_n_i(ce_n), .se_i(se), .wp_n_i(wp_n), .io_in_i(io_in),
        .io_out_o(io_out), .io_oe_o(io_oe), .rb_pull_o(rb_pull), .rd_data_i(rd_data),
        .busy_i(busy), .col_o(col), .cmd_vld_o(cmd_vld), .cmd_o(cmd),
        .addr_vld_o(addr_vld), .addr_idx_o(aidx), .addr_byte_o(abyte),
        .din_vld_o(din_vld), .din_o(din)
    );

    // Pulse monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (cmd_vld) begin n_cmd++; l_cmd = cmd; end
        if (addr_vld) begin n_addr++; l_abyte = abyte; l_aidx = aidx; end
        if (din_vld) begin n_din++; l_din = din; l_dcol = col; end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic c, input logic a, input logic [7:0] b);
        @(negedge clk); cle = c; ale = a; io_in = b; we_n = 0;
        waitn(6); we_n = 1;
        waitn(6); cle = 0; ale = 0;
    endtask

    task automatic bus_read(output logic [7:0] b, output logic oe);
        @(negedge clk); re_n = 0;
        waitn(6); b = io_out; oe = io_oe;
        re_n = 1; waitn(6);
    endtask

    // Model-checked operations.
    task automatic op_cmd(input logic [7:0] b, input string req);
        int c0 = n_cmd;
        bit blk = !wp_n && prot(b);
        bus_write(1, 0, b);
        chk(n_cmd == c0 + (blk ? 0 : 1), req, n_cmd - c0, blk ? 0 : 1);
        if (!blk) begin
            chk(l_cmd == b, req, l_cmd, b);
            m_acnt = 0;
        end
    endtask

    task automatic op_addr(input logic [7:0] b, input string req);
        int a0 = n_addr;
        bit exp_p = m_acnt <= ROWB;
        bus_write(0, 1, b);
        if (m_acnt == 0) m_col = (int'(b) >= TOTAL) ? TOTAL - 1 : int'(b);
        chk(n_addr == a0 + (exp_p ? 1 : 0), req, n_addr - a0, exp_p);
        if (exp_p) chk(l_aidx == 2'(m_acnt) && l_abyte == b, req, {l_aidx, l_abyte}, {2'(m_acnt), b});
        if (m_acnt <= ROWB) m_acnt++;
        chk(int'(col) == m_col, req, col, m_col);
    endtask

    task automatic op_data(input logic [7:0] b, input string req);
        int d0 = n_din;
        bit ok = sel(m_col, se);
        bus_write(0, 0, b);
        chk(n_din == d0 + (ok ? 1 : 0), req, n_din - d0, ok);
        if (ok) chk(l_din == b && int'(l_dcol) == m_col, req, {l_dcol, l_din}, {8'(m_col), b});
        m_col = nxt(m_col);
        chk(int'(col) == m_col, req, col, m_col);
    endtask

    task automatic op_read(input string req);
        logic [7:0] b; logic oe;
        logic [7:0] e = sel(m_col, se) ? pat(m_col) : 8'hFF;
        bus_read(b, oe);
        chk(oe == 1'b1, "R6", oe, 1);
        chk(b == e, req, b, e);
        m_col = nxt(m_col);
        chk(int'(col) == m_col, req, col, m_col);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int c0, d0, a0, kind;
        logic [7:0] b;
        logic oe;
        void'($urandom(32'h5EED_1234));
        waitn(4); rst_n = 1; waitn(2);
        // Reset state: R5 column, R6 enable, R8 pull-down
        chk(col == 0, "R5", col, 0);
        chk(io_oe == 0, "R6", io_oe, 0);
        chk(rb_pull == 0, "R8", rb_pull, 0);
        chk(n_cmd + n_addr + n_din == 0, "R1", n_cmd + n_addr + n_din, 0);

        op_cmd(8'h00, "R1");
        op_addr(8'd5, "R2");
        op_addr(8'h12, "R2");
        op_addr(8'h34, "R2");
        op_addr(8'h56, "R2");          // overflow byte: no pulse, column kept
        op_read("R5"); op_read("R5"); op_read("R5");
        op_data(8'hA5, "R3");
        // R4 illegal cycle
        c0 = n_cmd; a0 = n_addr; d0 = n_din;
        bus_write(1, 1, 8'h80);
        chk(n_cmd + n_addr + n_din == c0 + a0 + d0, "R4", n_cmd + n_addr + n_din, c0 + a0 + d0);
        chk(int'(col) == m_col, "R4", col, m_col);
        chk(io_oe == 0, "R6", io_oe, 0);

        // R7 deselect while busy keeps state; R8 follows busy with CE high
        busy = 1; waitn(2);
        ce_n = 1; waitn(6);
        chk(int'(col) == m_col, "R7", col, m_col);
        chk(rb_pull == 1, "R8", rb_pull, 1);
        // R11 strobes ignored while deselected
        c0 = n_cmd; d0 = n_din;
        bus_write(1, 0, 8'h00);
        bus_write(0, 0, 8'h3C);
        @(negedge clk); re_n = 0; waitn(6);
        chk(io_oe == 0, "R6", io_oe, 1'b0);
        re_n = 1; waitn(6);
        chk(n_cmd == c0 && n_din == d0, "R11", n_cmd + n_din, c0 + d0);
        chk(int'(col) == m_col, "R11", col, m_col);
        // R7 deselect while idle clears the column
        busy = 0; waitn(2);
        chk(rb_pull == 0, "R8", rb_pull, 0);
        ce_n = 0; waitn(6); ce_n = 1; waitn(6);
        m_col = 0; m_acnt = 0;
        chk(col == 0, "R7", col, 0);
        ce_n = 0; waitn(6);

        // R9 write protect
        wp_n = 0; waitn(2);
        op_cmd(8'h80, "R9");
        op_cmd(8'hD0, "R9");
        op_cmd(8'h00, "R9");
        wp_n = 1; waitn(2);
        op_cmd(8'h60, "R9");

        // R5 wrap at page end
        op_cmd(8'h00, "R1");
        op_addr(8'hFF, "R2");
        op_read("R5");
        chk(col == 0, "R5", col, 0);

        // R10 spare exclusion
        se = 1;
        op_cmd(8'h00, "R1");
        op_addr(8'(MAIN), "R10");
        op_read("R10");
        op_data(8'h77, "R10");
        se = 0;
        op_read("R10");

        // Random phase
        for (int i = 0; i < 300; i++) begin
            kind = $urandom_range(0, 3);
            se = 1'($urandom_range(0, 1));
            wp_n = 1'($urandom_range(0, 1));
            b = 8'($urandom);
            if ($urandom_range(0, 3) == 0) b = 8'h80;
            case (kind)
                0: op_cmd(b, "R9");
                1: op_addr(b, "R2");
                2: op_data(b, "R3");
                default: op_read("R5");
            endcase
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule